// File: doc/BRIEF.md
# I2C Port Expander Register Target

This block is an I2C target that controls an 8-bit general-purpose port. It holds four byte-wide registers: a read-only input image, an output latch, a polarity mask and a direction register. A bus master first sends a command byte that selects one of the four registers. It then writes data bytes into that register, or reads bytes back from it, until a later command byte selects another register. The selection survives stop and repeated-start conditions and never advances on its own.

SCL and SDA arrive as raw levels and pass through synchronizers clocked by a system clock that runs at least eight times faster than SCL. The block drives the bus only through an open-drain enable on SDA. Three strap inputs set the low bits of the target address. On the pin side, the block provides a data vector and a drive-enable vector for the pads, and it takes the pad levels back through a synchronizer.

The controller is one state machine with ten states:
- `ST_IDLE`: bus free, or a stop has been seen.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`, `ST_CMD_ACK`, `ST_WDATA_ACK`: the target pulls SDA low for the ninth clock.
- `ST_CMD`: shifting in the command byte.
- `ST_WDATA`: shifting in a write data byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RDATA_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: off the bus.

Transitions:
- Any state goes to `ST_ADDR` on a start and to `ST_IDLE` on a stop.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a full byte with a matching address, or to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read or `ST_CMD` for a write.
- `ST_CMD` goes to `ST_CMD_ACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate with each byte.
- `ST_RDATA` goes to `ST_RDATA_ACK`. From there the block returns to `ST_RDATA` on a master ACK, or goes to `ST_IGNORE` on a NACK.

Top module: `i2c_port_expander`

## Requirements
- R1: The target answers only the 7-bit address formed from binary 0111 in the upper four bits and `strap_i[2:0]` in the lower three. The eighth bit selects read (1) or write (0). After a mismatching address the block never pulls SDA and changes no register or selection until the next start or stop.
- R2: After a matching address byte, a command byte or a write data byte, the target holds SDA low through the ninth clock's high phase.
- R3: Only the low two bits of the command byte are decoded, and the upper six bits are ignored. The values select 0 = input image, 1 = output latch, 2 = polarity mask, 3 = direction.
- R4: The selection stays in force across stop, start and repeated start until a new command byte arrives. Every data byte of one transfer, written or read, uses that same register, with no increment.
- R5: Reading register 0 returns the synchronized pin levels XOR the polarity mask, whatever direction each pin has.
- R6: Data bytes written while register 0 is selected change no register and no pin output.
- R7: After reset the output latch is 0xFF, the polarity mask is 0x00, the direction register is 0xFF, the selection is 0, `pin_oe` is 0x00 and `sda_oe` is 0.
- R8: `pin_oe[i]` is the inverse of direction bit i, so 1 means input with the driver off. `pin_out` always carries the output latch.
- R9: Reading register 1 returns the stored latch value, not the pin levels.
- R10: Read bytes go out MSB first. The SDA drive changes only while SCL is low. A master ACK starts another byte from the same register. After a master NACK the target leaves SDA released until the next start or stop.
- R11: A start or stop before the eighth bit of a byte is complete aborts that byte, and no register or selection changes.
- R12: For a read of register 0, the value sent is captured at the SCL falling edge that begins that byte. Pin changes after that edge appear only in the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL bus level |
| sda_i | input | 1 | Raw SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 3 | Low three address bits |
| pin_in | input | 8 | Pad levels of the port |
| pin_out | output | 8 | Output latch value for the pads |
| pin_oe | output | 8 | Pad driver enable, 1 = drive |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- **Sticky selection.** Multi-byte writes and reads, and reads after a stop or repeated start, expose a pointer that increments or resets: it would return the wrong register.
- **Writes to register 0.** A write aimed at the input image would corrupt the latch or the direction bits on a faulty design.
- **Aborted bytes.** A byte cut short by a start or stop would commit a partial value if the design wrote too early.
- **Read-path details.** Changing the pins in the middle of a byte catches a capture point that is too late. Reading the latch while the pins disagree catches a read mux that returns pad levels. Checking SDA after a master NACK catches a target that keeps driving.
- **Address filter.** A foreign address must get no acknowledge and must leave all state untouched.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [SEL_W-1:0] {
        SEL_INPUT  = 2'd0,
        SEL_OUTPUT = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_e;
endpackage

// File: rtl/pexp_sync_vec.sv
module pexp_sync_vec #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= {W{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pexp_bus_events.sv
module pexp_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  =  scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl &  scl_prev;
    assign start_det =  scl_lvl &  scl_prev &  sda_prev & ~sda_lvl;
    assign stop_det  =  scl_lvl &  scl_prev & ~sda_prev &  sda_lvl;
endmodule

// File: rtl/pexp_regfile.sv
module pexp_regfile
    import pexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] pins_sync,
    input  logic              sel_we,
    input  reg_sel_e          sel_new,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_new,
    output reg_sel_e          sel_q,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] out_q,
    output logic [BYTE_W-1:0] inv_q,
    output logic [BYTE_W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_INPUT;
            out_q <= {BYTE_W{1'b1}};
            inv_q <= {BYTE_W{1'b0}};
            dir_q <= {BYTE_W{1'b1}};
        end else begin
            if (sel_we) sel_q <= sel_new;
            if (data_we) begin
                unique case (sel_q)
                    SEL_INPUT:  ;
                    SEL_OUTPUT: out_q <= data_new;
                    SEL_INVERT: inv_q <= data_new;
                    SEL_DIR:    dir_q <= data_new;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_INPUT:  rd_data = pins_sync ^ inv_q;
            SEL_OUTPUT: rd_data = out_q;
            SEL_INVERT: rd_data = inv_q;
            SEL_DIR:    rd_data = dir_q;
        endcase
    end
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
    import pexp_pkg::*;
#(
    parameter logic [3:0] BASE_ADDR   = 4'b0111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    input  logic [BYTE_W-1:0] pin_in,
    output logic [BYTE_W-1:0] pin_out,
    output logic [BYTE_W-1:0] pin_oe
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic [1:0]        bus_sync;
    logic              scl_lvl, sda_lvl;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] pins_sync;

    bus_state_e        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shift_q;
    logic              rw_q, mack_q, sda_oe_q;
    logic              byte_full, addr_hit, bus_event;

    reg_sel_e          sel_q;
    logic              sel_we, data_we;
    logic [BYTE_W-1:0] rd_data, out_q, inv_q, dir_q;

    pexp_sync_vec #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_sync)
    );
    assign scl_lvl = bus_sync[1];
    assign sda_lvl = bus_sync[0];

    pexp_sync_vec #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
    );

    pexp_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_full = (bit_cnt == FULL_CNT);
    assign addr_hit  = (shift_q[BYTE_W-1:1] == {BASE_ADDR, strap_i});
    assign bus_event = start_det | stop_det;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:
                    if (scl_fall && byte_full) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:
                    if (scl_fall && byte_full) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:
                    if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && byte_full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && bit_cnt == LAST_TX) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK:
                    if (scl_fall) state_nx = mack_q ? ST_RDATA : ST_IGNORE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and bus drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (bus_event) begin
            bit_cnt  <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && !byte_full) begin
                        shift_q <= {shift_q[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        bit_cnt <= '0;
                        if (state != ST_ADDR || addr_hit) sda_oe_q <= 1'b1;
                        if (state == ST_ADDR) rw_q <= shift_q[0];
                    end
                end
                ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe_q <= 1'b0;
                        if (state == ST_ADDR_ACK && rw_q) begin
                            shift_q  <= rd_data;
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                            bit_cnt  <= '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_TX) begin
                            sda_oe_q <= 1'b0;
                            bit_cnt  <= '0;
                        end else begin
                            shift_q  <= {shift_q[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~shift_q[BYTE_W-2];
                            bit_cnt  <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    if (scl_fall && mack_q) begin
                        shift_q  <= rd_data;
                        sda_oe_q <= ~rd_data[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    assign sel_we  = (state == ST_CMD)   && scl_fall && byte_full && !bus_event;
    assign data_we = (state == ST_WDATA) && scl_fall && byte_full && !bus_event;

    pexp_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync),
        .sel_we(sel_we), .sel_new(reg_sel_e'(shift_q[SEL_W-1:0])),
        .data_we(data_we), .data_new(shift_q),
        .sel_q(sel_q), .rd_data(rd_data),
        .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q)
    );

    assign sda_oe  = sda_oe_q;
    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/pexp_checker.sv
module pexp_checker
    import pexp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input bus_state_e        state,
    input logic              sda_oe,
    input logic              scl_lvl,
    input reg_sel_e          sel_q,
    input logic              sel_we,
    input logic              data_we,
    input logic [BYTE_W-1:0] pin_out,
    input logic [BYTE_W-1:0] pin_oe
);
    assert_quiet_off_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    assert_read_bit_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    assert_sel_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> $past(sel_we));

    assert_latch_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(data_we && sel_q == SEL_OUTPUT));

    assert_dir_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(data_we && sel_q == SEL_DIR));
endmodule

bind i2c_port_expander pexp_checker u_pexp_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe),
    .scl_lvl(scl_lvl), .sel_q(sel_q), .sel_we(sel_we), .data_we(data_we),
    .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/i2c_port_expander_tb.sv
module i2c_port_expander_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [7:0] pins = 8'h00;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_out = 8'hFF;
    logic [7:0] m_pol = 8'h00;
    logic [7:0] m_cfg = 8'hFF;
    logic [1:0] m_ptr = 2'd0;

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_port_expander u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .pin_in(pins),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] addr_byte(logic rd);
        return {4'b0111, strap, rd};
    endfunction

    function automatic logic [7:0] exp_reg(logic [1:0] s);
        case (s)
            2'd0:    return pins ^ m_pol;
            2'd1:    return m_out;
            2'd2:    return m_pol;
            default: return m_cfg;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(HALF);
        scl_drv = 1'b1; tick(HALF);
        sda_drv = 1'b0; tick(HALF);
        scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        tick(HALF);
        sda_drv = 1'b0; tick(HALF);
        scl_drv = 1'b1; tick(HALF);
        sda_drv = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(logic b);
        sda_drv = b; tick(HALF);
        scl_drv = 1'b1; tick(HALF);
        scl_drv = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; tick(HALF);
        scl_drv = 1'b1; tick(HALF/2);
        b = sda_line; tick(HALF - HALF/2);
        scl_drv = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!ack);
    endtask

    task automatic model_wr(logic [7:0] d);
        case (m_ptr)
            2'd1: m_out = d;
            2'd2: m_pol = d;
            2'd3: m_cfg = d;
            default: ;
        endcase
    endtask

    task automatic do_write(logic [7:0] cmd, int n, logic [23:0] dat, string tag);
        logic a;
        bus_start();
        send_byte(addr_byte(1'b0), a);
        check({tag, " R1 addr ack"}, {7'd0, a}, 8'd1);
        send_byte(cmd, a);
        check({tag, " R2 cmd ack"}, {7'd0, a}, 8'd1);
        m_ptr = cmd[1:0];
        for (int k = 0; k < n; k++) begin
            send_byte(dat[8*k +: 8], a);
            check({tag, " R2 data ack"}, {7'd0, a}, 8'd1);
            model_wr(dat[8*k +: 8]);
        end
        bus_stop();
    endtask

    task automatic do_read(int n, string tag);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(addr_byte(1'b1), a);
        check({tag, " R1 read addr ack"}, {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k < n - 1);
            check({tag, " R4 read data"}, d, exp_reg(m_ptr));
        end
        tick(3);
        check({tag, " R10 released after nack"}, {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    task automatic select(logic [7:0] cmd);
        do_write(cmd, 0, 24'd0, "select");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic b;
        logic [7:0] d;
        logic [7:0] p2;
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);

        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R7 reset state at the ports
        check("R7 pin_out reset", pin_out, 8'hFF);
        check("R7 pin_oe reset", pin_oe, 8'h00);
        check("R7 sda_oe reset", {7'd0, sda_oe}, 8'd0);

        // R5 input image from reset selection 0
        pins = 8'h5A;
        tick(5);
        do_read(1, "R5 reset sel");

        // R7 R3 reset values of each register
        select(8'h01); do_read(1, "R7 out");
        select(8'h02); do_read(1, "R7 pol");
        select(8'h03); do_read(1, "R7 cfg");

        // R1 foreign address: no ack, nothing changes
        bus_start();
        send_byte({4'b0111, ~strap, 1'b0}, a);
        check("R1 foreign addr nack", {7'd0, a}, 8'd0);
        send_byte(8'h01, a);
        check("R1 foreign cmd nack", {7'd0, a}, 8'd0);
        send_byte(8'h00, a);
        bus_stop();
        do_read(1, "R1 sel kept");
        check("R1 latch untouched", pin_out, 8'hFF);

        // R8 R3 direction and latch on the pins, upper command bits ignored
        do_write(8'h03, 1, 24'h00000F, "R8 cfg");
        check("R8 pin_oe from dir", pin_oe, 8'hF0);
        do_write(8'hFD, 1, 24'h0000A5, "R3 upper bits");
        check("R3 R8 pin_out latch", pin_out, 8'hA5);
        check("R8 pin_oe kept", pin_oe, 8'hF0);

        // R4 multi-byte write, repeated-start read and sticky selection
        do_write(8'h02, 3, 24'h332211, "R4 burst");
        check("R4 last byte kept", m_pol, 8'h33);
        bus_start();
        send_byte(addr_byte(1'b0), a);
        send_byte(8'h02, a);
        bus_start();
        send_byte(addr_byte(1'b1), a);
        check("R4 rs addr ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(d, k < 2);
            check("R4 R10 rs burst read", d, 8'h33);
        end
        bus_stop();
        do_read(1, "R4 after stop");

        // R9 latch readback independent of pins
        pins = 8'h5A;
        select(8'h01);
        do_read(2, "R9 latch");

        // R6 writes to register 0 are dropped; R5 reflects pins on outputs too
        do_write(8'h00, 3, 24'h000000, "R6 write input");
        check("R6 pin_out kept", pin_out, 8'hA5);
        check("R6 pin_oe kept", pin_oe, 8'hF0);
        pins = 8'hC3;
        tick(5);
        do_read(1, "R5 R6 input xor pol");
        select(8'h01); do_read(1, "R6 out kept");
        select(8'h03); do_read(1, "R6 cfg kept");

        // R11 stop in the middle of a data byte
        bus_start();
        send_byte(addr_byte(1'b0), a);
        send_byte(8'h01, a);
        m_ptr = 2'd1;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check("R11 stop abort latch", pin_out, 8'hA5);
        // R11 repeated start in the middle of a command byte
        bus_start();
        send_byte(addr_byte(1'b0), a);
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        bus_start();
        send_byte(addr_byte(1'b0), a);
        check("R11 restart addr ack", {7'd0, a}, 8'd1);
        bus_stop();
        do_read(1, "R11 sel unchanged");
        check("R11 pin_oe kept", pin_oe, 8'hF0);

        // R12 capture point of the input image
        select(8'h00);
        pins = 8'h96;
        p2   = 8'h3C;
        tick(5);
        bus_start();
        send_byte(addr_byte(1'b1), a);
        recv_bit(b);
        d[7] = b;
        pins = p2;
        for (int i = 6; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(1'b0);
        check("R12 first byte captured early", d, 8'h96 ^ m_pol);
        recv_byte(d, 1'b0);
        check("R12 second byte new pins", d, p2 ^ m_pol);
        tick(3);
        check("R10 nack release", {7'd0, sda_oe}, 8'd0);
        bus_stop();

        // random register traffic against the model (R3 R5 R8)
        for (int it = 0; it < 24; it++) begin
            logic [7:0] cmd;
            logic [7:0] dv;
            cmd  = 8'($urandom);
            dv   = 8'($urandom);
            pins = 8'($urandom);
            do_write(cmd, 1, {16'd0, dv}, "R3 random");
            check("R8 random pin_out", pin_out, m_out);
            check("R8 random pin_oe", pin_oe, ~m_cfg);
            do_read(1 + (it % 2), "R3 R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule